// File: doc/BRIEF.md
# Read-Modify-Write File Register Datapath

This block carries out the data half of byte and bit instructions on a file-register space that sits next to a single working register W. Once started, an operation fetches the byte at the addressed file location, combines it with W (add, subtract, logic, increment and so on) or changes one selected bit, and sends the result either to W or back to the same file location. Decoding and fetch are done elsewhere. The caller presents an already-decoded operation code, an 8-bit file address, a destination select, an access select, a bit index and a one-cycle start pulse.

Every operation that names a file location reads it in full before writing it, and this includes pure bit writes. The read strobe therefore reaches registers whose contents change when read. A bit set, clear or toggle writes back all eight bits as they were sampled. A flag that a read clears stays cleared, and a pin level seen on a port read is copied into the latch.

The file memory is outside the block. It must return `rd_data` combinationally for the `fa_out` presented in the same cycle as `rd_stb`, and it performs the write on the clock edge that ends a cycle with `wr_en` high.

Top module: `rmw_datapath`

## Requirements
- R1: With `abank`=0, an 8-bit address below 0x80 maps to 0x000+addr and one at or above 0x80 maps to 0xF00+addr. With `abank`=1 the 12-bit address is {bank register, addr}. Operation code 14 loads the bank register from `faddr[3:0]` and causes no file access.
- R2: When `start` is accepted with a code from 0 to 13, `rd_stb` is high for exactly the one cycle after the accepting edge. During that cycle `fa_out` carries the mapped address, and `fa_out` holds it through the following write cycle.
- R3: When the result goes to the file, `wr_en` is high for exactly the cycle after the read cycle and carries the result on `wr_data`. No other cycle has `wr_en` high.
- R4: For byte operations other than code 1, `dest`=0 places the result in W with no file write. `dest`=1 writes the file and leaves W unchanged. W is updated at the edge that ends the read cycle.
- R5: Byte codes: 0 copies f; 4 is f AND W; 5 is f OR W; 6 is f XOR W; 7 is NOT f; 8 is f+1; 9 is f-1; 10 gives 0. All results wrap to 8 bits.
- R6: Code 2 gives f+W with `carry` set to the carry out. Code 3 gives f-W with `carry` set to 1 exactly when f >= W, meaning no borrow. No other code changes `carry`.
- R7: `zero` is set to (result == 0) by codes 0, 2 to 10, and is left unchanged by codes 1 and 11 to 15.
- R8: Code 1 reads the file location and then writes the current W to it whatever `dest` is. W and flags stay unchanged.
- R9: Codes 11, 12 and 13 set, clear or toggle bit `bit_idx` of the byte just read and write all 8 bits back to the file whatever `dest` is. The other seven bits are written exactly as they were read, and W and flags stay unchanged.
- R10: `start` is ignored in the read cycle, so a held `start` begins a new operation every second cycle. Code 15 has no effect and no file access.
- R11: Synchronous active-high reset clears W, `zero`, `carry`, the bank register, `rd_stb` and `wr_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation with the presented operands |
| op | input | 4 | Decoded operation code |
| faddr | input | 8 | File address field |
| dest | input | 1 | 0: result to W, 1: result to file |
| abank | input | 1 | 0: access bank mapping, 1: banked mapping |
| bit_idx | input | 3 | Bit selected by bit operations |
| fa_out | output | 12 | Mapped file address |
| rd_stb | output | 1 | File read strobe, one cycle per operation |
| rd_data | input | 8 | File read data, valid in the rd_stb cycle |
| wr_en | output | 1 | File write enable |
| wr_data | output | 8 | File write data |
| wreg | output | 8 | Working register W |
| zero | output | 1 | Zero status |
| carry | output | 1 | Carry / no-borrow status |

## Verification
The hardest case to reach from the ports is the read side effect travelling through a bit write. A flag must be cleared by the read that a bit clear on a different bit of the same register makes, and the write-back must not restore it. The bench's file memory models a register whose top bit is a hardware flag that any read clears and that writes cannot set. It also models a port whose reads return pin levels that differ from its latch. A bit clear on bit 0 of the flag register is followed by a plain read into W, and W must then show the flag clear. A bit set on the port must leave the latch holding the pin levels plus the set bit.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

  typedef enum logic [3:0] {
    OP_MOV   = 4'd0,
    OP_MOVWF = 4'd1,
    OP_ADD   = 4'd2,
    OP_SUB   = 4'd3,
    OP_AND   = 4'd4,
    OP_IOR   = 4'd5,
    OP_XOR   = 4'd6,
    OP_COM   = 4'd7,
    OP_INC   = 4'd8,
    OP_DEC   = 4'd9,
    OP_CLR   = 4'd10,
    OP_BSET  = 4'd11,
    OP_BCLR  = 4'd12,
    OP_BTOG  = 4'd13,
    OP_BANK  = 4'd14,
    OP_NOP   = 4'd15
  } rmw_op_e;

  function automatic logic op_is_bit(rmw_op_e o);
    return o inside {OP_BSET, OP_BCLR, OP_BTOG};
  endfunction

  function automatic logic op_reads_file(rmw_op_e o);
    return (o != OP_BANK) && (o != OP_NOP);
  endfunction

  function automatic logic op_forces_file(rmw_op_e o);
    return op_is_bit(o) || (o == OP_MOVWF);
  endfunction

endpackage

// File: rtl/rmw_addr_map.sv
module rmw_addr_map #(
  parameter int unsigned FAW = 8,
  parameter int unsigned BW  = 4,
  parameter logic [FAW-1:0] SPLIT = 8'h80,
  localparam int unsigned AW = FAW + BW
) (
  input  logic [FAW-1:0] faddr,
  input  logic           banked,
  input  logic [BW-1:0]  bank,
  output logic [AW-1:0]  addr
);
  localparam logic [BW-1:0] LOW_BANK  = '0;
  localparam logic [BW-1:0] HIGH_BANK = '1;

  always_comb begin
    if (banked)
      addr = {bank, faddr};
    else if (faddr < SPLIT)
      addr = {LOW_BANK, faddr};
    else
      addr = {HIGH_BANK, faddr};
  end
endmodule

// File: rtl/rmw_bitop.sv
module rmw_bitop
  import rmw_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned BIW = $clog2(DW)
) (
  input  rmw_op_e        op,
  input  logic [DW-1:0]  din,
  input  logic [BIW-1:0] bit_idx,
  output logic [DW-1:0]  dout
);
  for (genvar g = 0; g < DW; g++) begin : g_bit
    logic sel;
    assign sel = (bit_idx == BIW'(g));
    always_comb begin
      unique case (op)
        OP_BSET: dout[g] = din[g] | sel;
        OP_BCLR: dout[g] = din[g] & ~sel;
        OP_BTOG: dout[g] = din[g] ^ sel;
        default: dout[g] = din[g];
      endcase
    end
  end
endmodule

// File: rtl/rmw_alu.sv
module rmw_alu
  import rmw_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  rmw_op_e       op,
  input  logic [DW-1:0] fval,
  input  logic [DW-1:0] wval,
  input  logic [DW-1:0] bitres,
  output logic [DW-1:0] res,
  output logic          c_out,
  output logic          upd_z,
  output logic          upd_c
);
  logic [DW:0] sum;
  logic [DW:0] dif;

  assign sum = {1'b0, fval} + {1'b0, wval};
  assign dif = {1'b0, fval} - {1'b0, wval};

  always_comb begin
    res   = fval;
    c_out = 1'b0;
    upd_z = 1'b1;
    upd_c = 1'b0;
    unique case (op)
      OP_MOV:   res = fval;
      OP_MOVWF: begin res = wval; upd_z = 1'b0; end
      OP_ADD:   begin res = sum[DW-1:0]; c_out = sum[DW];  upd_c = 1'b1; end
      OP_SUB:   begin res = dif[DW-1:0]; c_out = ~dif[DW]; upd_c = 1'b1; end
      OP_AND:   res = fval & wval;
      OP_IOR:   res = fval | wval;
      OP_XOR:   res = fval ^ wval;
      OP_COM:   res = ~fval;
      OP_INC:   res = fval + DW'(1);
      OP_DEC:   res = fval - DW'(1);
      OP_CLR:   res = '0;
      OP_BSET, OP_BCLR, OP_BTOG: begin res = bitres; upd_z = 1'b0; end
      default:  upd_z = 1'b0;
    endcase
  end
endmodule

// File: rtl/rmw_datapath.sv
module rmw_datapath
  import rmw_pkg::*;
#(
  parameter int unsigned DW  = 8,
  parameter int unsigned FAW = 8,
  parameter int unsigned BW  = 4,
  parameter int unsigned OPW = 4,
  localparam int unsigned AW  = FAW + BW,
  localparam int unsigned BIW = $clog2(DW)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [OPW-1:0] op,
  input  logic [FAW-1:0] faddr,
  input  logic           dest,
  input  logic           abank,
  input  logic [BIW-1:0] bit_idx,
  output logic [AW-1:0]  fa_out,
  output logic           rd_stb,
  input  logic [DW-1:0]  rd_data,
  output logic           wr_en,
  output logic [DW-1:0]  wr_data,
  output logic [DW-1:0]  wreg,
  output logic           zero,
  output logic           carry
);
  rmw_op_e        op_in;
  rmw_op_e        op_q;
  logic           dest_q;
  logic [BIW-1:0] bit_q;
  logic [BW-1:0]  bank_q;
  logic [AW-1:0]  addr_map;
  logic [DW-1:0]  bit_res;
  logic [DW-1:0]  alu_res;
  logic           alu_c;
  logic           alu_uz;
  logic           alu_uc;
  logic           to_file;

  assign op_in   = rmw_op_e'(op);
  assign to_file = dest_q | op_forces_file(op_q);

  rmw_addr_map #(.FAW(FAW), .BW(BW)) u_map (
    .faddr (faddr),
    .banked(abank),
    .bank  (bank_q),
    .addr  (addr_map)
  );

  rmw_bitop #(.DW(DW)) u_bit (
    .op     (op_q),
    .din    (rd_data),
    .bit_idx(bit_q),
    .dout   (bit_res)
  );

  rmw_alu #(.DW(DW)) u_alu (
    .op    (op_q),
    .fval  (rd_data),
    .wval  (wreg),
    .bitres(bit_res),
    .res   (alu_res),
    .c_out (alu_c),
    .upd_z (alu_uz),
    .upd_c (alu_uc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_stb  <= 1'b0;
      wr_en   <= 1'b0;
      wr_data <= '0;
      fa_out  <= '0;
      wreg    <= '0;
      zero    <= 1'b0;
      carry   <= 1'b0;
      bank_q  <= '0;
      op_q    <= OP_NOP;
      dest_q  <= 1'b0;
      bit_q   <= '0;
    end else begin
      wr_en <= 1'b0;
      if (rd_stb) begin
        rd_stb <= 1'b0;
        if (to_file) begin
          wr_en   <= 1'b1;
          wr_data <= alu_res;
        end else begin
          wreg <= alu_res;
        end
        if (alu_uz) zero  <= (alu_res == '0);
        if (alu_uc) carry <= alu_c;
      end else if (start) begin
        if (op_reads_file(op_in)) begin
          rd_stb <= 1'b1;
          fa_out <= addr_map;
          op_q   <= op_in;
          dest_q <= dest;
          bit_q  <= bit_idx;
        end else if (op_in == OP_BANK) begin
          bank_q <= faddr[BW-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/rmw_datapath_chk.sv
module rmw_datapath_chk
  import rmw_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_stb,
  input logic          wr_en,
  input logic [DW-1:0] wreg,
  input logic          zero,
  input logic          carry,
  input rmw_op_e       op_q
);
  p_read_one_clk_r2: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> !rd_stb);

  p_write_after_read_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(rd_stb));

  p_write_single_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  p_wreg_kept_r4: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $stable(wreg));

  p_movwf_to_file_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && op_q == OP_MOVWF) |=> (wr_en && $stable(zero) && $stable(carry)));

  p_bitop_to_file_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && op_is_bit(op_q)) |=> (wr_en && $stable(zero) && $stable(carry)));
endmodule

bind rmw_datapath rmw_datapath_chk #(.DW(DW)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .rd_stb(rd_stb),
  .wr_en (wr_en),
  .wreg  (wreg),
  .zero  (zero),
  .carry (carry),
  .op_q  (op_q)
);

// File: tb/rmw_datapath_tb.sv
`timescale 1ns/1ps
module rmw_datapath_tb;
  localparam int FLAG_A = 'hF81;
  localparam int PORT_A = 'hF82;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  op = 4'd15;
  logic [7:0]  faddr = '0;
  logic        dest = 1'b0;
  logic        abank = 1'b0;
  logic [2:0]  bit_idx = '0;
  logic [11:0] fa_out;
  logic        rd_stb;
  logic [7:0]  rd_data;
  logic        wr_en;
  logic [7:0]  wr_data;
  logic [7:0]  wreg;
  logic        zero;
  logic        carry;

  logic [7:0] mem [4096];
  logic [7:0] pins;
  logic [7:0] port_latch;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // expected state of the reference model
  bit        m_rd, m_wr, m_z, m_c;
  int        m_fa, m_wd, m_w, m_bank;
  int        p_op, p_bit;
  bit        p_dest;

  always #10 clk = ~clk;

  assign rd_data = (fa_out == 12'(PORT_A)) ? pins : mem[fa_out];

  rmw_datapath u_dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .faddr(faddr),
    .dest(dest), .abank(abank), .bit_idx(bit_idx), .fa_out(fa_out),
    .rd_stb(rd_stb), .rd_data(rd_data), .wr_en(wr_en), .wr_data(wr_data),
    .wreg(wreg), .zero(zero), .carry(carry)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int read_val(int a);
    return (a == PORT_A) ? int'(pins) : int'(mem[a]);
  endfunction

  function automatic int map_addr(int fa, bit a, int bank);
    if (a) return bank * 256 + fa;
    if (fa >= 'h80) return 'hF00 + fa;
    return fa;
  endfunction

  task automatic tick();
    bit n_rd = m_rd, n_wr = 1'b0, n_z = m_z, n_c = m_c, tofile;
    int n_fa = m_fa, n_wd = m_wd, n_w = m_w, n_bank = m_bank;
    int v, r;
    bit c_rd, c_wr;
    int c_fa, c_wd;
    if (rst) begin
      n_rd = 0; n_w = 0; n_z = 0; n_c = 0; n_bank = 0;
    end else if (m_rd) begin
      v = read_val(m_fa);
      tofile = p_dest;
      r = v;
      case (p_op)
        1:  begin r = m_w; tofile = 1; end
        2:  begin r = (v + m_w) % 256; n_c = (v + m_w) > 255; end
        3:  begin r = (v - m_w + 256) % 256; n_c = (v >= m_w); end
        4:  r = v & m_w;
        5:  r = v | m_w;
        6:  r = v ^ m_w;
        7:  r = 255 - v;
        8:  r = (v + 1) % 256;
        9:  r = (v + 255) % 256;
        10: r = 0;
        11: begin r = v | (1 << p_bit); tofile = 1; end
        12: begin r = v & ~(1 << p_bit) & 255; tofile = 1; end
        13: begin r = v ^ (1 << p_bit); tofile = 1; end
        default: r = v;
      endcase
      if (p_op == 0 || (p_op >= 2 && p_op <= 10)) n_z = (r == 0);
      n_rd = 0;
      if (tofile) begin n_wr = 1; n_wd = r; end
      else n_w = r;
    end else if (start) begin
      if (op <= 13) begin
        n_rd = 1;
        n_fa = map_addr(int'(faddr), abank, m_bank);
        p_op = int'(op); p_dest = dest; p_bit = int'(bit_idx);
      end else if (op == 14) begin
        n_bank = int'(faddr[3:0]);
      end
    end
    c_rd = rd_stb; c_wr = wr_en; c_fa = int'(fa_out); c_wd = int'(wr_data);
    @(posedge clk);
    #1;
    if (c_rd && c_fa == FLAG_A) mem[FLAG_A][7] = 1'b0;
    if (c_wr) begin
      if (c_fa == FLAG_A) mem[FLAG_A][6:0] = 7'(c_wd);
      else if (c_fa == PORT_A) port_latch = 8'(c_wd);
      else mem[c_fa] = 8'(c_wd);
    end
    m_rd = n_rd; m_wr = n_wr; m_z = n_z; m_c = n_c;
    m_fa = n_fa; m_wd = n_wd; m_w = n_w; m_bank = n_bank;
    @(negedge clk);
    if (rst) begin
      // R11 reset state
      check(!rd_stb && !wr_en && wreg == 0 && !zero && !carry, "R11",
            {rd_stb, wr_en, zero, carry, wreg}, 0);
    end else begin
      check(rd_stb == m_rd, "R2", rd_stb, m_rd);
      if (m_rd) check(int'(fa_out) == m_fa, "R1", fa_out, m_fa);
      check(wr_en == m_wr, "R3", wr_en, m_wr);
      if (m_wr) check(int'(wr_data) == m_wd, "R5", wr_data, m_wd);
      check(int'(wreg) == m_w, "R4", wreg, m_w);
      check(zero == m_z, "R7", zero, m_z);
      check(carry == m_c, "R6", carry, m_c);
    end
  endtask

  task automatic issue(input int o, input int fa, input bit d, input bit a, input int b);
    op = 4'(o); faddr = 8'(fa); dest = d; abank = a; bit_idx = 3'(b);
    start = 1'b1;
    tick();
    start = 1'b0;
    tick();
    tick();
  endtask

  initial begin
    int pulses;
    foreach (mem[i]) mem[i] = 8'h00;
    mem['h010] = 8'h3C; mem['h011] = 8'hC5; mem['h012] = 8'h3C;
    mem['h205] = 8'hFF; mem['hF90] = 8'h5A; mem[FLAG_A] = 8'h85;
    pins = 8'hA0; port_latch = 8'h0F;
    @(negedge clk);
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R5 R4 copy into W
    issue(0, 'h10, 0, 0, 0);
    // R6 add with carry out
    issue(2, 'h11, 0, 0, 0);
    issue(0, 'h10, 0, 0, 0);
    // R6 R7 subtract equal to file, zero and no borrow
    issue(3, 'h12, 1, 0, 0);
    issue(3, 'h11, 0, 0, 0);
    issue(0, 'h10, 0, 0, 0);
    // R6 subtract with borrow
    issue(3, 'h20, 0, 0, 0);
    // R5 logic and unary ops
    issue(4, 'h11, 0, 0, 0);
    issue(5, 'h11, 0, 0, 0);
    issue(6, 'h11, 0, 0, 0);
    issue(7, 'h11, 1, 0, 0);
    issue(8, 'h11, 0, 0, 0);
    issue(9, 'h20, 0, 0, 0);
    issue(10, 'h11, 1, 0, 0);
    // R1 banked access after bank load
    issue(14, 'h02, 0, 0, 0);
    issue(0, 'h05, 0, 1, 0);
    issue(8, 'h05, 1, 1, 0);
    // R1 upper access bank
    issue(0, 'h90, 0, 0, 0);
    // R9 bit ops ignore dest
    issue(11, 'h10, 0, 0, 7);
    issue(12, 'h10, 0, 0, 2);
    issue(13, 'h10, 1, 0, 0);
    // R8 store W
    issue(1, 'h30, 0, 0, 0);
    check(mem['h030] == wreg, "R8", mem['h030], wreg);
    // R9 read-cleared flag stays clear after bit clear on bit 0
    issue(12, 'h81, 1, 0, 0);
    issue(0, 'h81, 0, 0, 0);
    check(wreg == 8'h04, "R9", wreg, 8'h04);
    // R9 port bit set copies pin levels into latch
    issue(11, 'h82, 1, 0, 0);
    check(port_latch == 8'hA1, "R9", port_latch, 8'hA1);
    // R10 code 15 does nothing
    op = 4'd15; start = 1'b1;
    tick();
    start = 1'b0;
    check(rd_stb == 1'b0, "R10", rd_stb, 0);
    tick();
    // R10 held start: reads every second cycle
    pulses = 0;
    op = 4'd0; faddr = 8'h10; dest = 1'b0; abank = 1'b0; start = 1'b1;
    for (int i = 0; i < 6; i++) begin
      tick();
      if (rd_stb) pulses++;
    end
    start = 1'b0;
    tick(); tick();
    check(pulses == 3, "R10", pulses, 3);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule